// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Unit

This block is a watchdog that can only be armed by a fixed handshake. Software writes two distinct 16-bit key values, in order, to a control word, each time with an enable bit set. Arming is only possible while a configuration word selects the watchdog mode and releases both counter halves. Once armed, a 64-bit counter advances on each pulse of a free-running tick input. When the counter reaches a programmed 64-bit period, the unit raises a reset request.

While armed, software keeps the system alive by repeating the same two-key sequence, which reloads the counter to zero. Any control write whose key is neither of the two values forces a reset request at once. The request is latched and stays high until the block's own asynchronous reset. The request output is meant to drive the system reset controller.

Top module: `wdk_watchdog`

## Requirements
- R1: Asynchronous reset leaves the unit disarmed, with counter zero, period zero, configuration zero and `rst_req` low.
- R2: A control write (address 0) carries the enable flag in bit 14 and the key in bits 31:16. When disarmed, the unit moves to the pre-armed state only if the key is 0xA5C6, the enable flag is set and the gate is open. The gate is open when the configuration word (address 3) has bits 3:2 equal to 2 and bits 1:0 equal to 3. While the gate is closed, control writes have no effect.
- R3: In the pre-armed state, key 0xDA7E with the enable flag set arms the unit. Key 0xA5C6 with the enable flag set keeps it pre-armed. Counting starts only once the unit is armed.
- R4: When disarmed or pre-armed, any other control write (wrong key or enable flag clear) returns the unit to disarmed and never raises `rst_req`.
- R5: While armed, a control write whose key is neither 0xA5C6 nor 0xDA7E raises `rst_req` on the next clock edge, whatever the enable flag.
- R6: While armed, each clock with `tick` high either expires or increments the counter. If the counter is already greater than or equal to the period, `rst_req` rises on that edge; otherwise the counter increments. With period P, the expiry happens on tick P+1, so a period of zero expires on the first tick. The period is written as a low word (address 1) and a high word (address 2).
- R7: While armed, key 0xA5C6 followed later by key 0xDA7E is a kick that reloads the counter to zero. A kick takes priority over a tick in the same cycle, including a tick that would have expired.
- R8: Once high, `rst_req` stays high until `rst_n` is asserted.
- R9: Writes to the period words are ignored while armed.
- R10: While armed, key 0xDA7E without a preceding 0xA5C6, or a repeated 0xA5C6, neither trips nor kicks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 period low, 2 period high, 3 configuration |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Count tick, one clock wide per count |
| rst_req | output | 1 | Latched reset request |

## Verification
Every result of this block is due on the clock edge that consumes the stimulus: a control write changes the key state, and a trip raises `rst_req`, on that edge. A tick either advances the counter or, at expiry, raises `rst_req` on that same edge. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares `rst_req` with the model on each following falling edge, so each expected value is sampled exactly one edge after the stimulus. Explicit checks at hand-counted tick positions also confirm the expiry at tick P+1, the kick timing and the trip timing.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int KEY_W = 16;
  localparam int CFG_W = 4;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;
  localparam logic [1:0]       MODE_WDOG  = 2'b10;

  typedef enum logic [1:0] {
    WDK_IDLE = 2'd0,
    WDK_PRE  = 2'd1,
    WDK_LIVE = 2'd2,
    WDK_HALF = 2'd3
  } wdk_state_e;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             en_bit,
  input  logic             gate_open,
  output logic             live,
  output logic             kick,
  output logic             bad_key
);
  wdk_state_e state_q, state_d;
  logic is_first, is_second;

  assign is_first  = (key_val == KEY_FIRST);
  assign is_second = (key_val == KEY_SECOND);

  always_comb begin
    state_d = state_q;
    kick    = 1'b0;
    bad_key = 1'b0;
    if (key_wr) begin
      unique case (state_q)
        WDK_IDLE: if (gate_open && en_bit && is_first) state_d = WDK_PRE;
        WDK_PRE: begin
          if (en_bit && is_first)       state_d = WDK_PRE;
          else if (en_bit && is_second) state_d = WDK_LIVE;
          else                          state_d = WDK_IDLE;
        end
        WDK_LIVE: begin
          if (is_first)        state_d = WDK_HALF;
          else if (!is_second) bad_key = 1'b1;
        end
        WDK_HALF: begin
          if (is_second) begin
            state_d = WDK_LIVE;
            kick    = 1'b1;
          end else if (!is_first) begin
            bad_key = 1'b1;
          end
        end
        default: state_d = WDK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WDK_IDLE;
    else        state_q <= state_d;
  end

  assign live = (state_q == WDK_LIVE) || (state_q == WDK_HALF);

  AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(live)) |-> ($past(state_q) == WDK_PRE)); // R3

endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, reached;

  assign reached = (cnt_q >= period);
  assign expire  = run && tick && !kick && reached;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (kick) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && tick && !reached) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 3,
  parameter int EN_BIT  = 14,
  parameter int KEY_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              rst_req
);
  localparam int PRD_WORDS = CNT_W / DATA_W;
  localparam int CFG_ADDR  = PRD_WORDS + 1;

  logic [CNT_W-1:0] prd_q;
  logic [CFG_W-1:0] cfg_q;
  logic             live, kick, bad_key, expire;
  logic             ctrl_wr, cfg_wr, gate_open;
  logic             req_q, req_set;

  assign ctrl_wr   = wr_en && (wr_addr == '0);
  assign cfg_wr    = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign gate_open = (cfg_q[3:2] == MODE_WDOG) && (&cfg_q[1:0]);

  generate
    for (genvar g = 0; g < PRD_WORDS; g++) begin : g_prd
      logic word_we;
      assign word_we = wr_en && !live && (wr_addr == ADDR_W'(g + 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prd_q[g*DATA_W +: DATA_W] <= '0;
        else if (word_we) prd_q[g*DATA_W +: DATA_W] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wr_data[CFG_W-1:0];
  end

  wdk_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (ctrl_wr),
    .key_val  (wr_data[KEY_LSB +: KEY_W]),
    .en_bit   (wr_data[EN_BIT]),
    .gate_open(gate_open),
    .live     (live),
    .kick     (kick),
    .bad_key  (bad_key)
  );

  wdk_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (live),
    .tick  (tick),
    .kick  (kick),
    .period(prd_q),
    .expire(expire)
  );

  assign req_set = bad_key || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (req_set) req_q <= 1'b1;
  end

  assign rst_req = req_q;

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q); // R8
  AST_REQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(live)); // R5
  AST_PRD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(live) |-> $stable(prd_q)); // R9

endmodule

// File: tb/wdk_watchdog_tb_top.sv
module wdk_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        rst_req;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  int              m_st;
  longint unsigned m_cnt, m_prd;
  logic [3:0]      m_cfg;
  bit              m_req;

  always #4 clk = ~clk;

  wdk_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .rst_req(rst_req)
  );

  // behavioural reference: disarmed 0, pre-armed 1, armed 2, armed-half-kick 3
  always @(posedge clk) begin
    bit live, kick, bad, hit, gate;
    logic [15:0] key;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_prd = 0; m_cfg = 0; m_req = 0;
    end else begin
      live = (m_st >= 2);
      kick = 0; bad = 0;
      gate = (m_cfg == 4'hB);
      if (wr_en && wr_addr == 3'd0) begin
        key = wr_data[31:16];
        if (m_st == 0) begin
          if (gate && wr_data[14] && key == 16'hA5C6) m_st = 1;
        end else if (m_st == 1) begin
          if (wr_data[14] && key == 16'hA5C6) m_st = 1;
          else if (wr_data[14] && key == 16'hDA7E) m_st = 2;
          else m_st = 0;
        end else if (m_st == 2) begin
          if (key == 16'hA5C6) m_st = 3;
          else if (key != 16'hDA7E) bad = 1;
        end else begin
          if (key == 16'hDA7E) begin kick = 1; m_st = 2; end
          else if (key != 16'hA5C6) bad = 1;
        end
      end
      hit = live && tick && !kick && (m_cnt >= m_prd);
      if (kick) m_cnt = 0;
      else if (live && tick && !hit) m_cnt = m_cnt + 1;
      if (wr_en && !live && wr_addr == 3'd1) m_prd[31:0] = wr_data;
      if (wr_en && !live && wr_addr == 3'd2) m_prd[63:32] = wr_data;
      if (wr_en && wr_addr == 3'd3) m_cfg = wr_data[3:0];
      if (bad || hit) m_req = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (rst_req !== m_req) begin
        fails++;
        $display("FAIL %s: rst_req actual %b expected %b (model)", cur_req, rst_req, m_req);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d, input bit tk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic key(input logic [15:0] k, input bit en, input bit tk = 1'b0);
    cyc(1'b1, 3'd0, {k, 1'b0, en, 14'b0}, tk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'h0, 1'b1);
  endtask

  task automatic chk(input string req, input logic exp);
    vectors++;
    if (rst_req !== exp) begin
      fails++;
      $display("FAIL %s: rst_req actual %b expected %b", req, rst_req, exp);
    end
  endtask

  task automatic do_reset();
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] prd_lo, input logic [31:0] prd_hi);
    cyc(1'b1, 3'd3, 32'hB, 1'b0);
    cyc(1'b1, 3'd1, prd_lo, 1'b0);
    cyc(1'b1, 3'd2, prd_hi, 1'b0);
    key(16'hA5C6, 1'b1);
    key(16'hDA7E, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1"; chk("R1", 1'b0);

    // R2: gate closed, keys ignored, period 0 would expire instantly if armed
    cur_req = "R2";
    key(16'hA5C6, 1'b1); key(16'hDA7E, 1'b1); key(16'h1234, 1'b1);
    ticks(10); chk("R2", 1'b0);

    // R4: enable flag clear blocks arming
    do_reset(); cur_req = "R4";
    cyc(1'b1, 3'd3, 32'hB, 1'b0);
    key(16'hA5C6, 1'b0); key(16'hDA7E, 1'b1); key(16'h1111, 1'b1);
    ticks(3); chk("R4", 1'b0);
    // R4: wrong key in pre-armed state returns to disarmed
    key(16'hA5C6, 1'b1); key(16'h0000, 1'b1); key(16'hDA7E, 1'b1);
    key(16'h2222, 1'b1); ticks(3); chk("R4", 1'b0);

    // R3/R6: period zero expires on first tick
    do_reset(); cur_req = "R6";
    arm(32'd0, 32'd0); chk("R3", 1'b0);
    ticks(1); chk("R6", 1'b1);

    // R6/R8: period 5 expires on tick 6 and latches
    do_reset(); cur_req = "R6";
    arm(32'd5, 32'd0);
    ticks(5); chk("R6", 1'b0);
    ticks(1); chk("R6", 1'b1);
    cur_req = "R8";
    ticks(4); key(16'hA5C6, 1'b1); key(16'hDA7E, 1'b1); chk("R8", 1'b1);
    do_reset(); chk("R8", 1'b0);

    // R7: kick reloads counter
    cur_req = "R7";
    arm(32'd5, 32'd0);
    ticks(4); key(16'hA5C6, 1'b1); key(16'hDA7E, 1'b1);
    ticks(5); chk("R7", 1'b0);
    ticks(1); chk("R7", 1'b1);

    // R7: kick wins over an expiring tick in the same cycle
    do_reset();
    arm(32'd3, 32'd0);
    ticks(3); key(16'hA5C6, 1'b1); key(16'hDA7E, 1'b1, 1'b1);
    chk("R7", 1'b0);
    ticks(3); chk("R7", 1'b0);
    ticks(1); chk("R7", 1'b1);

    // R5: bad key trips on the next edge
    do_reset(); cur_req = "R5";
    arm(32'd100, 32'd0); ticks(2); chk("R5", 1'b0);
    key(16'h1111, 1'b1); chk("R5", 1'b1);
    // R5: enable flag clear still trips
    do_reset();
    arm(32'd100, 32'd0);
    key(16'hBEEF, 1'b0); chk("R5", 1'b1);

    // R10: lone second key and repeated first key neither trip nor kick
    do_reset(); cur_req = "R10";
    arm(32'd3, 32'd0);
    ticks(2); key(16'hDA7E, 1'b1); chk("R10", 1'b0);
    key(16'hA5C6, 1'b1); key(16'hA5C6, 1'b0); chk("R10", 1'b0);
    ticks(1); chk("R10", 1'b0);
    ticks(1); chk("R10", 1'b1);

    // R9: period write while armed ignored
    do_reset(); cur_req = "R9";
    arm(32'd3, 32'd0);
    ticks(3);
    cyc(1'b1, 3'd1, 32'd100, 1'b0);
    cyc(1'b1, 3'd2, 32'd1, 1'b0);
    chk("R9", 1'b0);
    ticks(1); chk("R9", 1'b1);

    // R6: high word of period takes part in comparison
    do_reset(); cur_req = "R6";
    arm(32'd0, 32'd1);
    ticks(50); chk("R6", 1'b0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule